// File: doc/BRIEF.md
# Up/Down Counter with Asynchronous Load

This block is a small binary counter that steps once on each rising clock edge when enabled. A direction input selects whether it increments or decrements. The sequence wraps through all 2^WIDTH states in both directions. A level-sensitive load input makes the count follow a data bus while it is held high, without waiting for the clock. An active-low master reset clears the count at once and outranks every other input.

An active-low terminal-count output marks the last state in the current direction. That is the all-ones value when counting up and zero when counting down. The flag is qualified by the count enable, so a following stage can take this output as its own enable and the stages form a longer counter. The flag is purely combinational, so it follows the count, direction and enable without any clock delay.

Top module: `updn_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 immediately and stays 0 regardless of clock, load, enable, direction and data.
- R2: While rst_ni is high and load_i is high, count_o equals data_i at all times, including straight after a data change or reset release between clock edges, and across clock edges, whatever cnt_en_ni and up_i are.
- R3: With rst_ni high and load_i low, count_o changes only at a rising edge of clk_i; between edges it is stable.
- R4: With cnt_en_ni low and up_i = 1, each rising edge adds one, and the all-ones value (15 at WIDTH 4) steps to 0.
- R5: With cnt_en_ni low and up_i = 0, each rising edge subtracts one, and 0 steps to the all-ones value.
- R6: With cnt_en_ni high, count_o keeps its value across clock edges.
- R7: tc_no is 0 exactly when cnt_en_ni is 0 and either up_i = 1 with count_o all ones, or up_i = 0 with count_o = 0; otherwise tc_no is 1.
- R8: tc_no responds to a change of cnt_en_ni or up_i without a clock edge.
- R9: After load_i or rst_ni is released, the first enabled rising edge steps from the loaded or cleared value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous master clear, active low, highest priority |
| load_i | input | 1 | Asynchronous transparent load, active high |
| cnt_en_ni | input | 1 | Count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| data_i | input | WIDTH | Value taken while load_i is high |
| count_o | output | WIDTH | Current count |
| tc_no | output | 1 | Terminal count flag, active low, gated by the enable |

## Verification
The hardest state to reach is the boundary between asynchronous and clocked control. This covers data that changes while the load is held between clock edges, and reset released while the load is still high, where the count must take the bus value with no edge at all. The stimulus changes data_i, load_i and rst_ni at mid-cycle points chosen away from the rising edge and samples count_o one nanosecond later. It then runs the clock with the load still held to show that edges do not disturb the loaded value. The terminal flag's dependence on enable and direction is exercised the same way: it is parked on the all-ones and zero states with the enable high, and the enable and direction are flipped between edges.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_next.sv
module updn_next #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             en_ni,
  output logic [WIDTH-1:0] nxt_o
);
  import updn_pkg::*;

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  dir_e dir;
  assign dir = dir_e'(up_i);

  always_comb begin
    if (en_ni) begin
      nxt_o = cnt_i;
    end else begin
      unique case (dir)
        DIR_UP:   nxt_o = cnt_i + ONE;
        default:  nxt_o = cnt_i - ONE;
      endcase
    end
  end
endmodule

// File: rtl/updn_bit.sv
module updn_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic data_i,
  input  logic next_i,
  output logic q_o
);
  // Async set/clear pair. Includes rst_ni so that reset release with load high re-loads.
  logic ld_set;
  logic ld_clr;
  assign ld_set = rst_ni & load_i & data_i;
  assign ld_clr = rst_ni & load_i & ~data_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge ld_set or posedge ld_clr) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= data_i;
    else             q_o <= next_i;
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             en_ni,
  output logic             tc_no
);
  logic at_top;
  logic at_bot;
  logic at_end;

  assign at_top = &cnt_i;
  assign at_bot = ~|cnt_i;
  assign at_end = up_i ? at_top : at_bot;
  assign tc_no  = ~(~en_ni & at_end);
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cnt_en_ni,
  input  logic             up_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_no
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  updn_next #(.WIDTH(WIDTH)) u_next (
    .cnt_i (cnt_q),
    .up_i  (up_i),
    .en_ni (cnt_en_ni),
    .nxt_o (cnt_nxt)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    updn_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .data_i (data_i[b]),
      .next_i (cnt_nxt[b]),
      .q_o    (cnt_q[b])
    );
  end

  updn_tc #(.WIDTH(WIDTH)) u_tc (
    .cnt_i (cnt_q),
    .up_i  (up_i),
    .en_ni (cnt_en_ni),
    .tc_no (tc_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             cnt_en_ni,
  input logic             up_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_no
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0); // R1

  AST_LOAD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> count_o == data_i); // R2

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_ni && up_i) |=> (load_i || count_o == $past(count_o) + ONE)); // R4

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_ni && !up_i) |=> (load_i || count_o == $past(count_o) - ONE)); // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_ni) |=> (load_i || $stable(count_o))); // R6

  AST_TC_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_no |-> (!cnt_en_ni && (up_i ? count_o == ALL1 : count_o == '0))); // R7

  AST_TC_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_ni && ((up_i && count_o == ALL1) || (!up_i && count_o == '0))) |-> !tc_no); // R7
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .cnt_en_ni (cnt_en_ni),
  .up_i      (up_i),
  .data_i    (data_i),
  .count_o   (count_o),
  .tc_no     (tc_no)
);

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
  localparam int unsigned WIDTH = 4;

  logic             clk_i     = 1'b0;
  logic             rst_ni    = 1'b1;
  logic             load_i    = 1'b0;
  logic             cnt_en_ni = 1'b1;
  logic             up_i      = 1'b1;
  logic [WIDTH-1:0] data_i    = '0;
  logic [WIDTH-1:0] count_o;
  logic             tc_no;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  updn_counter #(.WIDTH(WIDTH)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .cnt_en_ni (cnt_en_ni),
    .up_i      (up_i),
    .data_i    (data_i),
    .count_o   (count_o),
    .tc_no     (tc_no)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Rising edge, then 2 ns later: away from the edge.
  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  function automatic int tc_ref(input int c, input logic up, input logic en_n);
    if (!en_n && ((up && c == 15) || (!up && c == 0))) return 0;
    return 1;
  endfunction

  task automatic do_load(input int v);
    data_i = WIDTH'(v);
    load_i = 1'b1;
    step();
    load_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    load_i = 1'b1; data_i = 4'd9; cnt_en_ni = 1'b0; up_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1 check("R1", "reset with load high", int'(count_o), 0);
    step(); step();
    check("R1", "reset across edges", int'(count_o), 0);
    rst_ni = 1'b1;
    #1 check("R2", "reset release with load high", int'(count_o), 9);
    check("R7", "tc at 9 up", int'(tc_no), 1);
  endtask

  task automatic t_load_async();
    load_i = 1'b1; cnt_en_ni = 1'b0;
    for (int v = 3; v < 16; v += 5) begin
      data_i = WIDTH'(v);
      #1 check("R2", "data change mid cycle", int'(count_o), v);
    end
    up_i = 1'b0;
    data_i = 4'd6;
    step();
    check("R2", "load held across edge", int'(count_o), 6);
    data_i = 4'd11;
    #1 check("R2", "data change after edge", int'(count_o), 11);
  endtask

  task automatic t_release();
    up_i = 1'b1; cnt_en_ni = 1'b0; load_i = 1'b1; data_i = 4'd5;
    step();
    load_i = 1'b0;
    #1 check("R9", "load released keeps value", int'(count_o), 5);
    step();
    check("R9", "first edge steps from loaded", int'(count_o), 6);
    #1 rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    #1 check("R1", "cleared mid count", int'(count_o), 0);
    step();
    check("R9", "first edge steps from reset", int'(count_o), 1);
  endtask

  task automatic t_count_up();
    int exp;
    cnt_en_ni = 1'b0; up_i = 1'b1;
    do_load(13);
    exp = 13;
    for (int i = 0; i < 5; i++) begin
      step();
      exp = (exp + 1) % 16;
      check("R4", "up step", int'(count_o), exp);
      check("R7", "tc up", int'(tc_no), tc_ref(exp, 1'b1, 1'b0));
    end
  endtask

  task automatic t_count_down();
    int exp;
    cnt_en_ni = 1'b0; up_i = 1'b0;
    do_load(2);
    exp = 2;
    for (int i = 0; i < 5; i++) begin
      step();
      exp = (exp + 15) % 16;
      check("R5", "down step", int'(count_o), exp);
      check("R7", "tc down", int'(tc_no), tc_ref(exp, 1'b0, 1'b0));
    end
  endtask

  task automatic t_between_edges();
    cnt_en_ni = 1'b0; up_i = 1'b1;
    do_load(7);
    step();
    check("R3", "stepped", int'(count_o), 8);
    #4 check("R3", "stable between edges", int'(count_o), 8);
  endtask

  task automatic t_hold();
    cnt_en_ni = 1'b1; up_i = 1'b1;
    do_load(15);
    for (int i = 0; i < 3; i++) step();
    check("R6", "hold at 15", int'(count_o), 15);
    check("R7", "tc gated by enable", int'(tc_no), 1);
    up_i = 1'b0;
    step();
    check("R6", "hold with down", int'(count_o), 15);
  endtask

  task automatic t_tc_comb();
    cnt_en_ni = 1'b1; up_i = 1'b1;
    do_load(15);
    check("R8", "tc idle at 15", int'(tc_no), 1);
    cnt_en_ni = 1'b0;
    #1 check("R8", "tc after enable low", int'(tc_no), 0);
    up_i = 1'b0;
    #1 check("R8", "tc after direction down at 15", int'(tc_no), 1);
    cnt_en_ni = 1'b1;
    do_load(0);
    check("R7", "tc 0 disabled", int'(tc_no), 1);
    cnt_en_ni = 1'b0;
    #1 check("R8", "tc at 0 down enabled", int'(tc_no), 0);
    up_i = 1'b1;
    #1 check("R8", "tc at 0 up", int'(tc_no), 1);
    cnt_en_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load_async();
    t_release();
    t_count_up();
    t_count_down();
    t_between_edges();
    t_hold();
    t_tc_comb();
    step();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule